// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address sequence of a four-beat burst for a synchronous memory. A start strobe captures a full address: its two least significant bits seed the burst, while the remaining upper bits are frozen for the whole burst. Each cycle with the advance input high moves the burst one beat forward. The low two bits of the output follow either a wrap-around increment or an interleaved order. In the interleaved order, the start bits are XORed with a beat count that begins at zero.

The order is chosen by a mode pin that is sampled together with the strobe. Only a logic 0 selects the increment order. Every other value selects the interleaved order, which is the default. A flag marks the fourth beat. Control is a three-state machine:

- **IDLE**: after reset, no burst has been loaded.
- **RUN**: beats 0 to 2 of a burst.
- **FINAL**: beat 3 of a burst.

The machine has four transitions:

- **load**: any state goes to RUN on a strobe.
- **near_end**: RUN goes to FINAL when an advance leaves beat 2.
- **wrap**: FINAL goes back to RUN on an advance, and the beat count returns to 0.
- **stay**: otherwise the state is held.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, the output address is all zeros and the last-beat flag is low.
- R2: A strobe takes priority over advance and is accepted in any state, including mid-burst. In the cycle after the strobe edge, the output address equals the address that was presented, and the last-beat flag is low.
- R3: When the mode pin was 0 at the strobe, output bits [1:0] on beat k equal (start + k) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R4: When the mode pin was 1 at the strobe, output bits [1:0] on beat k equal start XOR k. For example, a start of 1 gives 1, 0, 3, 2.
- R5: The mode pin is sampled only on a strobe edge. Changing it during a burst has no effect on the sequence.
- R6: With advance low and no strobe, the output address holds its value.
- R7: The upper address bits, [ADDR_W-1:2], stay at their captured value through the entire burst. This includes the wrap: no carry passes out of the two low bits.
- R8: The last-beat flag is high exactly while the beat count is 3.
- R9: An advance on the fourth beat returns the beat count to 0, so the start address reappears, and the burst keeps running.
- R10: In IDLE, advance is ignored, and the output stays at zero until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Starts a burst from addr_i |
| addr_i | input | ADDR_W | Start address |
| mode_i | input | 1 | 0 selects increment order; anything else selects interleaved |
| adv_i | input | 1 | Steps the burst one beat |
| addr_o | output | ADDR_W | Current beat address |
| last_o | output | 1 | High on the fourth beat |

## Verification
Every combination of start value (0 to 3) and order is run, each with three different upper-bit patterns. Each run lasts nine-plus beats with gaps in the advance input. This separates the increment order from the interleaved order: starts 1 and 3 differ between them, while starts 0 and 2 do not. It also exposes any carry into the upper bits, and it shows the wrap. A second pass toggles the mode pin on every cycle of a burst, to show that the order was frozen at the strobe. Further passes restrike the strobe mid-burst with advance high, and pulse advance before any burst has been loaded.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int BEAT_W = 2;
    localparam int BEATS  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FINAL = 2'd2
    } bseq_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bseq_order_e;
endpackage

// File: rtl/bseq_beat_fsm.sv
module bseq_beat_fsm
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] beat_o,
    output logic              last_o,
    output logic              active_o
);
    localparam logic [BEAT_W-1:0] BEAT_PENULT = BEAT_W'(BEATS - 2);
    localparam logic [BEAT_W-1:0] BEAT_TOP    = BEAT_W'(BEATS - 1);

    bseq_state_e       state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;

    // next-state and beat counter
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        if (load_i) begin
            state_d = ST_RUN;          // transition: load
            beat_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE; // stay: advance ignored
                end
                ST_RUN: begin
                    if (step_i) begin
                        beat_d = beat_q + 1'b1;
                        if (beat_q == BEAT_PENULT) begin
                            state_d = ST_FINAL; // transition: near_end
                        end
                    end
                end
                ST_FINAL: begin
                    if (step_i) begin
                        beat_d  = '0;
                        state_d = ST_RUN;       // transition: wrap
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    beat_d  = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // outputs
    always_comb begin
        beat_o   = beat_q;
        last_o   = (state_q == ST_FINAL);
        active_o = (state_q != ST_IDLE);
    end

    // R8: the flag from the state and the separate beat counter agree
    p_last_at_top_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (beat_o == BEAT_TOP));

    p_top_beat_is_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && beat_o == BEAT_TOP) |-> last_o);

    // R9: an advance on the fourth beat wraps the count
    p_beat_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && step_i && !load_i) |=> (beat_o == '0 && !last_o && active_o));

    // R10: idle ignores advance
    p_idle_ignores_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !load_i) |=> (!active_o && beat_o == '0));
endmodule

// File: rtl/bseq_base_latch.sv
module bseq_base_latch
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     mode_i,
    output logic [ADDR_W-BEAT_W-1:0] upper_o,
    output logic [BEAT_W-1:0]        start_o,
    output bseq_order_e              order_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] start_q;
    bseq_order_e       order_q;
    bseq_order_e       order_in;

    // only a definite 0 selects increment order
    always_comb begin
        order_in = (mode_i == 1'b0) ? ORD_LINEAR : ORD_INTERLEAVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load_i) begin
            upper_q <= addr_i[ADDR_W-1:BEAT_W];
            start_q <= addr_i[BEAT_W-1:0];
            order_q <= order_in;
        end
    end

    assign upper_o = upper_q;
    assign start_o = start_q;
    assign order_o = order_q;

    // R5 / R7: captured fields are frozen between strobes
    p_base_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(upper_o) && $stable(start_o)));

    p_order_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(order_o));
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
    import bseq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  bseq_order_e       order_i,
    output logic [BEAT_W-1:0] offs_o
);
    always_comb begin
        unique case (order_i)
            ORD_LINEAR:     offs_o = start_i + beat_i; // wraps modulo 4
            ORD_INTERLEAVE: offs_o = start_i ^ beat_i;
            default:        offs_o = start_i;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper;
    logic [BEAT_W-1:0] start;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] offs;
    bseq_order_e       order;
    logic              active;

    bseq_base_latch #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (strobe_i),
        .addr_i  (addr_i),
        .mode_i  (mode_i),
        .upper_o (upper),
        .start_o (start),
        .order_o (order)
    );

    bseq_beat_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (strobe_i),
        .step_i   (adv_i),
        .beat_o   (beat),
        .last_o   (last_o),
        .active_o (active)
    );

    bseq_order_map u_map (
        .start_i (start),
        .beat_i  (beat),
        .order_i (order),
        .offs_o  (offs)
    );

    assign addr_o = {upper, offs};

    // R2: the strobe presents the captured address on the next cycle
    p_load_presents_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (addr_o == $past(addr_i) && !last_o));

    // R6: no advance, no strobe -> address holds
    p_hold_without_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && !adv_i) |=> $stable(addr_o));

    // R7: upper bits never move without a strobe
    p_upper_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    // R10: before the first burst the address stays zero
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (addr_o == '0));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strobe_i;
    logic [AW-1:0] addr_i;
    logic          mode_i;
    logic          adv_i;
    logic [AW-1:0] addr_o;
    logic          last_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state, computed from the requirements
    bit         m_act;
    bit [AW-3:0] m_up;
    int         m_st;
    bit         m_lin;
    int         m_beat;

    always #4 clk = ~clk; // 125 MHz

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .addr_i   (addr_i),
        .mode_i   (mode_i),
        .adv_i    (adv_i),
        .addr_o   (addr_o),
        .last_o   (last_o)
    );

    function automatic logic [AW-1:0] exp_addr();
        int off;
        if (!m_act) return '0;
        if (m_lin) off = (m_st + m_beat) % 4;
        else       off = m_st ^ m_beat;
        return {m_up, 2'(off)};
    endfunction

    task automatic check(string tag, logic [AW-1:0] act_a, logic [AW-1:0] exp_a,
                         logic act_l, logic exp_l);
        n_chk++;
        if (act_a !== exp_a) begin
            n_bad++;
            $display("FAIL %s addr actual=%h expected=%h", tag, act_a, exp_a);
        end
        n_chk++;
        if (act_l !== exp_l) begin
            n_bad++;
            $display("FAIL R8 (%s) last actual=%b expected=%b", tag, act_l, exp_l);
        end
    endtask

    // one clock: drive, update model at the edge, sample 1 ns later
    task automatic cyc(string tag, bit stb, logic [AW-1:0] a, bit md, bit adv);
        strobe_i = stb;
        addr_i   = a;
        mode_i   = md;
        adv_i    = adv;
        @(posedge clk);
        if (stb) begin
            m_act  = 1'b1;
            m_up   = a[AW-1:2];
            m_st   = int'(a[1:0]);
            m_lin  = (md == 1'b0);
            m_beat = 0;
        end else if (m_act && adv) begin
            m_beat = (m_beat + 1) % 4; // R9 wrap
        end
        #1;
        check(tag, addr_o, exp_addr(), last_o, m_act && (m_beat == 3));
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit [AW-3:0] ups[3];
        ups[0] = '0;
        ups[1] = '1;
        ups[2] = 6'h2A;
        rst_n = 1'b0;
        strobe_i = 0; addr_i = '0; mode_i = 0; adv_i = 0;
        m_act = 0; m_up = '0; m_st = 0; m_lin = 0; m_beat = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", addr_o, '0, last_o, 1'b0);
        rst_n = 1'b1;

        // R10: advance before any burst
        for (int i = 0; i < 4; i++) cyc("R10 idle adv", 0, 8'hFF, 1, 1);

        // R3/R4/R6/R7/R9 sweep
        for (int md = 0; md < 2; md++) begin
            for (int u = 0; u < 3; u++) begin
                for (int s = 0; s < 4; s++) begin
                    cyc("R2 load", 1, {ups[u], 2'(s)}, md[0], 1);
                    for (int k = 0; k < 12; k++) begin
                        cyc(md == 0 ? "R3 R7 R9 linear" : "R4 R7 R9 interleave",
                            0, 8'h55, ~md[0], (k % 3) != 2); // R6 gaps
                    end
                end
            end
        end

        // R5: mode pin toggles during a burst
        for (int s = 0; s < 4; s++) begin
            cyc("R2 load", 1, {6'h11, 2'(s)}, 0, 0);
            for (int k = 0; k < 8; k++) cyc("R5 mode frozen", 0, '0, k[0], 1);
            cyc("R2 load", 1, {6'h22, 2'(s)}, 1, 0);
            for (int k = 0; k < 8; k++) cyc("R5 mode frozen", 0, '0, ~k[0], 1);
        end

        // R2: restrike mid-burst with advance high, including on the last beat
        cyc("R2 load", 1, 8'h93, 1, 0);
        cyc("R4", 0, '0, 1, 1);
        cyc("R2 restrike", 1, 8'h6E, 0, 1);
        cyc("R3", 0, '0, 0, 1);
        cyc("R3", 0, '0, 0, 1);
        cyc("R3", 0, '0, 0, 1);
        cyc("R2 restrike last", 1, 8'hC1, 1, 1);
        cyc("R6 hold", 0, '0, 1, 0);
        cyc("R6 hold", 0, '0, 1, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule